// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit decides, for one branch request at a time, whether a conditional branch is taken, and it works out where the branch goes. Each request carries a 2-bit condition code from the preceding operation and a 4-bit selection mask. Any subset of the four outcomes (equal, low, high, overflow) can make the branch taken. A single request can therefore express sixteen branch conditions, from "never" through "not equal" to "always".

Two target forms are supported, and the mask means the same thing in both:

- **Storage form.** The target is a base register value, plus an optional index register value, plus a 12-bit unsigned displacement. The sum wraps at 24 bits.
- **Register form.** The target is the contents of one register, truncated to 24 bits.

A register selector of zero is never read as register 0:

- In the storage form, a zero base or index selector contributes nothing to the sum.
- In the register form, a zero selector cancels the branch.

Register values arrive on input ports, because the register file lives elsewhere. Results are registered and appear one cycle after the request, marked by a valid strobe.

Top module: `brc_resolve`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `res_valid`, `res_taken` and `res_target` are all 0.
- R2: `res_valid` is 1 in exactly the cycles that follow a cycle with `req_valid` = 1. Taken and target belong to that request.
- R3: The condition code encodes 0 = equal/zero, 1 = low/minus, 2 = high/plus, 3 = overflow. Mask bits are numbered 0 to 3 from the left (bit 0 is `br_mask[3]`). The branch is taken when the mask bit whose number equals `cond_code` is 1.
- R4: Mask 4'b0000 is never taken. Mask 4'b1111 is taken for every condition code, apart from the case in R9.
- R5: Composite masks follow R3. Mask 4'b0111 is taken unless the code is 0 (not equal). Mask 4'b1011 is taken unless the code is 1 (not low). Mask 4'b1101 is taken unless the code is 2 (not high).
- R6: With `req_fmt` = 1 (storage form), `res_target` = base term + index term + zero-extended `disp`, modulo 2^24.
- R7: In the storage form, a `base_sel` or `idx_sel` of 0 makes that term zero, whatever the matching value port holds. Otherwise the term is the low 24 bits of that value port.
- R8: With `req_fmt` = 0 (register form) and `tgt_sel` ≠ 0, `res_target` is the low 24 bits of `tgt_val`.
- R9: With `req_fmt` = 0 and `tgt_sel` = 0, `res_taken` = 0 and `res_target` = 0, for any mask.
- R10: In a cycle after one without a request, `res_taken` and `res_target` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | A branch request is present this cycle |
| req_fmt | input | 1 | 0 = register form, 1 = storage form |
| cond_code | input | 2 | Current condition code |
| br_mask | input | 4 | Branch mask, bit 0 = MSB |
| tgt_sel | input | 4 | Register selector for the register form |
| tgt_val | input | 32 | Contents of the register named by `tgt_sel` |
| base_sel | input | 4 | Base register selector for the storage form |
| base_val | input | 32 | Contents of the base register |
| idx_sel | input | 4 | Index register selector for the storage form |
| idx_val | input | 32 | Contents of the index register |
| disp | input | 12 | Unsigned displacement |
| res_valid | output | 1 | Result strobe, one cycle after a request |
| res_taken | output | 1 | Branch taken |
| res_target | output | 24 | Branch target address |

## Verification
Every result (strobe, taken flag and target) is due exactly one clock edge after the edge that captures the request. No result may appear in any other cycle.

The driver applies each request half a period before the capturing edge and queues the expected item. The monitor samples at the following falling edge, where it pops one item whenever the strobe is high. A strobe with nothing queued fails R2, as does an item still queued at the end.

Hold behaviour and the reset state are sampled at falling edges after idle cycles. This keeps every sample clear of the edge that moves the outputs.

// File: rtl/brc_pkg.sv
package brc_pkg;

  // Target form selected by a request.
  typedef enum logic {
    FMT_REG = 1'b0,
    FMT_STG = 1'b1
  } brc_fmt_e;

  // Condition code values.
  localparam logic [1:0] CC_EQ  = 2'd0;
  localparam logic [1:0] CC_LOW = 2'd1;
  localparam logic [1:0] CC_HI  = 2'd2;
  localparam logic [1:0] CC_OVF = 2'd3;

endpackage

// File: rtl/brc_cond_match.sv
module brc_cond_match #(
  parameter int MASK_W = 4,
  localparam int CC_W  = $clog2(MASK_W)
) (
  input  logic [MASK_W-1:0] mask,
  input  logic [CC_W-1:0]   cc,
  output logic              hit
);

  // One select line per condition; mask bit k (from the left) lives at MASK_W-1-k.
  logic [MASK_W-1:0] sel;

  for (genvar k = 0; k < MASK_W; k++) begin : g_sel
    assign sel[k] = (cc == CC_W'(k)) & mask[MASK_W-1-k];
  end

  assign hit = |sel;

endmodule

// File: rtl/brc_addr_gen.sv
module brc_addr_gen
  import brc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12,
  parameter int RSEL_W = 4
) (
  input  brc_fmt_e          fmt,
  input  logic [RSEL_W-1:0] tgt_sel,
  input  logic [REG_W-1:0]  tgt_val,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic [REG_W-1:0]  base_val,
  input  logic [RSEL_W-1:0] idx_sel,
  input  logic [REG_W-1:0]  idx_val,
  input  logic [DISP_W-1:0] disp,
  output logic [ADDR_W-1:0] target,
  output logic              reg_null
);

  localparam int PAD_W = ADDR_W - DISP_W;

  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] idx_term;
  logic [ADDR_W-1:0] disp_term;
  logic [ADDR_W-1:0] stg_sum;
  logic [ADDR_W-1:0] reg_term;

  // A zero selector stands for "no register", never register 0.
  always_comb begin
    base_term = (base_sel != '0) ? base_val[ADDR_W-1:0] : '0;
    idx_term  = (idx_sel  != '0) ? idx_val[ADDR_W-1:0]  : '0;
  end

  assign disp_term = {{PAD_W{1'b0}}, disp};
  assign stg_sum   = base_term + idx_term + disp_term;

  assign reg_null  = (tgt_sel == '0);
  assign reg_term  = reg_null ? '0 : tgt_val[ADDR_W-1:0];

  always_comb begin
    unique case (fmt)
      FMT_STG: target = stg_sum;
      default: target = reg_term;
    endcase
  end

endmodule

// File: rtl/brc_out_reg.sv
module brc_out_reg #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              taken_d,
  input  logic [ADDR_W-1:0] target_d,
  output logic              valid_q,
  output logic              taken_q,
  output logic [ADDR_W-1:0] target_q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= 1'b0;
      taken_q  <= 1'b0;
      target_q <= '0;
    end else begin
      valid_q <= load;
      if (load) begin
        taken_q  <= taken_d;
        target_q <= target_d;
      end
    end
  end

endmodule

// File: rtl/brc_resolve.sv
module brc_resolve
  import brc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12,
  parameter int RSEL_W = 4,
  parameter int MASK_W = 4,
  localparam int CC_W  = $clog2(MASK_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_fmt,
  input  logic [CC_W-1:0]   cond_code,
  input  logic [MASK_W-1:0] br_mask,
  input  logic [RSEL_W-1:0] tgt_sel,
  input  logic [REG_W-1:0]  tgt_val,
  input  logic [RSEL_W-1:0] base_sel,
  input  logic [REG_W-1:0]  base_val,
  input  logic [RSEL_W-1:0] idx_sel,
  input  logic [REG_W-1:0]  idx_val,
  input  logic [DISP_W-1:0] disp,
  output logic              res_valid,
  output logic              res_taken,
  output logic [ADDR_W-1:0] res_target
);

  brc_fmt_e          fmt;
  logic              cond_hit;
  logic              reg_null;
  logic              taken_d;
  logic [ADDR_W-1:0] target_d;

  assign fmt = brc_fmt_e'(req_fmt);

  brc_cond_match #(
    .MASK_W(MASK_W)
  ) u_match (
    .mask(br_mask),
    .cc  (cond_code),
    .hit (cond_hit)
  );

  brc_addr_gen #(
    .ADDR_W(ADDR_W),
    .REG_W (REG_W),
    .DISP_W(DISP_W),
    .RSEL_W(RSEL_W)
  ) u_addr (
    .fmt     (fmt),
    .tgt_sel (tgt_sel),
    .tgt_val (tgt_val),
    .base_sel(base_sel),
    .base_val(base_val),
    .idx_sel (idx_sel),
    .idx_val (idx_val),
    .disp    (disp),
    .target  (target_d),
    .reg_null(reg_null)
  );

  // The register form with no register named is cancelled.
  assign taken_d = cond_hit & ~((fmt == FMT_REG) & reg_null);

  brc_out_reg #(
    .ADDR_W(ADDR_W)
  ) u_out (
    .clk     (clk),
    .rst     (rst),
    .load    (req_valid),
    .taken_d (taken_d),
    .target_d(target_d),
    .valid_q (res_valid),
    .taken_q (res_taken),
    .target_q(res_target)
  );

endmodule

// File: rtl/brc_resolve_chk.sv
module brc_resolve_chk #(
  parameter int ADDR_W = 24,
  parameter int REG_W  = 32,
  parameter int DISP_W = 12,
  parameter int RSEL_W = 4,
  parameter int MASK_W = 4,
  localparam int CC_W  = $clog2(MASK_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_fmt,
  input logic [CC_W-1:0]   cond_code,
  input logic [MASK_W-1:0] br_mask,
  input logic [RSEL_W-1:0] tgt_sel,
  input logic [REG_W-1:0]  tgt_val,
  input logic              res_valid,
  input logic              res_taken,
  input logic [ADDR_W-1:0] res_target
);

  logic reg_zero;
  logic mask_bit;

  assign reg_zero = !req_fmt && (tgt_sel == '0);
  assign mask_bit = br_mask[(MASK_W-1) - int'(cond_code)];

  assert_strobe_set_R2: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> res_valid);

  assert_strobe_clr_R2: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !res_valid);

  assert_mask_pick_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !reg_zero) |=> (res_taken == $past(mask_bit)));

  assert_never_R4: assert property (@(posedge clk) disable iff (rst)
    (req_valid && br_mask == '0) |=> !res_taken);

  assert_reg_target_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_fmt && tgt_sel != '0) |=>
      (res_target == $past(tgt_val[ADDR_W-1:0])));

  assert_reg_zero_R9: assert property (@(posedge clk) disable iff (rst)
    (req_valid && reg_zero) |=> (!res_taken && res_target == '0));

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> ($stable(res_taken) && $stable(res_target)));

endmodule

bind brc_resolve brc_resolve_chk #(
  .ADDR_W(ADDR_W),
  .REG_W (REG_W),
  .DISP_W(DISP_W),
  .RSEL_W(RSEL_W),
  .MASK_W(MASK_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_fmt   (req_fmt),
  .cond_code (cond_code),
  .br_mask   (br_mask),
  .tgt_sel   (tgt_sel),
  .tgt_val   (tgt_val),
  .res_valid (res_valid),
  .res_taken (res_taken),
  .res_target(res_target)
);

// File: tb/sim_brc_resolve.sv
`timescale 1ns/1ps
module sim_brc_resolve;

  logic        clk = 1'b0;
  logic        rst;
  logic        req_valid;
  logic        req_fmt;
  logic [1:0]  cond_code;
  logic [3:0]  br_mask;
  logic [3:0]  tgt_sel;
  logic [31:0] tgt_val;
  logic [3:0]  base_sel;
  logic [31:0] base_val;
  logic [3:0]  idx_sel;
  logic [31:0] idx_val;
  logic [11:0] disp;
  logic        res_valid;
  logic        res_taken;
  logic [23:0] res_target;

  typedef struct {
    logic        taken;
    logic [23:0] target;
    string       tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_run  = 0;
  int   n_fail = 0;
  logic last_taken;
  logic [23:0] last_target;

  always #2.5 clk = ~clk;

  brc_resolve u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_fmt(req_fmt),
    .cond_code(cond_code), .br_mask(br_mask), .tgt_sel(tgt_sel),
    .tgt_val(tgt_val), .base_sel(base_sel), .base_val(base_val),
    .idx_sel(idx_sel), .idx_val(idx_val), .disp(disp),
    .res_valid(res_valid), .res_taken(res_taken), .res_target(res_target)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Mask bit numbered cc from the left is taken (R3).
  function automatic logic model_hit(logic [3:0] m, logic [1:0] cc);
    return m[3 - int'(cc)];
  endfunction

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drive_stg(string tag, logic [3:0] m, logic [1:0] cc,
                           logic [3:0] bs, logic [31:0] bv,
                           logic [3:0] xs, logic [31:0] xv, logic [11:0] d);
    exp_t e;
    logic [23:0] bt, xt;
    @(negedge clk);
    req_valid = 1'b1; req_fmt = 1'b1; cond_code = cc; br_mask = m;
    base_sel = bs; base_val = bv; idx_sel = xs; idx_val = xv; disp = d;
    tgt_sel = 4'd5; tgt_val = 32'hDEAD_BEEF;
    bt = (bs != 0) ? bv[23:0] : 24'd0;
    xt = (xs != 0) ? xv[23:0] : 24'd0;
    e.taken = model_hit(m, cc);
    e.target = bt + xt + {12'd0, d};
    e.tag = tag;
    exp_q.push_back(e);
    last_taken = e.taken; last_target = e.target;
  endtask

  task automatic drive_reg(string tag, logic [3:0] m, logic [1:0] cc,
                           logic [3:0] ts, logic [31:0] tv);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_fmt = 1'b0; cond_code = cc; br_mask = m;
    tgt_sel = ts; tgt_val = tv;
    base_sel = 4'd3; base_val = 32'h0012_3456; idx_sel = 4'd4;
    idx_val = 32'h0000_0100; disp = 12'h0AB;
    e.taken  = (ts == 0) ? 1'b0 : model_hit(m, cc);
    e.target = (ts == 0) ? 24'd0 : tv[23:0];
    e.tag = tag;
    exp_q.push_back(e);
    last_taken = e.taken; last_target = e.target;
  endtask

  // Monitor: results are due one edge after the capturing edge.
  always @(negedge clk) begin
    if (!rst && res_valid) begin
      if (exp_q.size() == 0) begin
        check("R2", "unexpected strobe", 32'd1, 32'd0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        check(e.tag, "taken", {31'd0, res_taken}, {31'd0, e.taken});
        check(e.tag, "target", {8'd0, res_target}, {8'd0, e.target});
      end
    end
  end

  initial begin
    #(5ns * 20000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; req_valid = 1'b1; req_fmt = 1'b1; cond_code = 2'd0;
    br_mask = 4'hF; tgt_sel = 4'd1; tgt_val = 32'h1; base_sel = 4'd1;
    base_val = 32'h55; idx_sel = 4'd0; idx_val = 32'h0; disp = 12'h1;
    repeat (3) @(negedge clk);
    check("R1", "valid in reset", {31'd0, res_valid}, 32'd0);
    check("R1", "taken in reset", {31'd0, res_taken}, 32'd0);
    check("R1", "target in reset", {8'd0, res_target}, 32'd0);
    req_valid = 1'b0;
    rst = 1'b0;
    @(negedge clk);
    check("R1", "valid after reset", {31'd0, res_valid}, 32'd0);
    check("R1", "target after reset", {8'd0, res_target}, 32'd0);

    // R3/R4/R5: every mask against every condition code, storage form.
    for (int m = 0; m < 16; m++) begin
      for (int c = 0; c < 4; c++) begin
        string t;
        t = (m == 0 || m == 15) ? "R4" :
            (m == 7 || m == 11 || m == 13) ? "R5" : "R3";
        drive_stg(t, 4'(m), 2'(c), 4'd2, 32'h0000_1000 + 32'(m * 64),
                  4'd6, 32'(c * 16), 12'(m + c));
      end
    end
    idle();

    // R6: wrap at 24 bits, upper register bits ignored.
    drive_stg("R6", 4'hF, 2'd1, 4'd1, 32'hAB_FFFFF0, 4'd2, 32'h77_000020, 12'hFFF);
    drive_stg("R6", 4'h8, 2'd0, 4'd9, 32'h0000_0000, 4'd10, 32'h0000_0000, 12'h800);
    // R7: zero selectors ignore the value ports.
    drive_stg("R7", 4'hF, 2'd2, 4'd0, 32'h00FF_FFFF, 4'd3, 32'h0000_0010, 12'h004);
    drive_stg("R7", 4'hF, 2'd3, 4'd7, 32'h0000_0200, 4'd0, 32'h00AA_AAAA, 12'h001);
    drive_stg("R7", 4'h4, 2'd1, 4'd0, 32'h0012_3456, 4'd0, 32'h0065_4321, 12'hABC);
    // R8: register form.
    drive_reg("R8", 4'h2, 2'd2, 4'd14, 32'hFF12_3456);
    drive_reg("R8", 4'h2, 2'd3, 4'd1,  32'h0000_0004);
    drive_reg("R8", 4'h1, 2'd3, 4'd15, 32'h00AB_CDEF);
    // R9: register form with selector zero.
    drive_reg("R9", 4'hF, 2'd0, 4'd0, 32'h0055_5555);
    drive_reg("R9", 4'h8, 2'd0, 4'd0, 32'h0000_1234);
    // R10: hold over idle cycles.
    idle();
    idle();
    @(negedge clk);
    check("R10", "held taken", {31'd0, res_taken}, {31'd0, last_taken});
    check("R10", "held target", {8'd0, res_target}, {8'd0, last_target});
    check("R2", "no strobe when idle", {31'd0, res_valid}, 32'd0);
    drive_stg("R10", 4'hD, 2'd1, 4'd1, 32'h0000_0300, 4'd0, 32'h0, 12'h010);
    idle();
    repeat (3) @(negedge clk);
    check("R10", "held taken", {31'd0, res_taken}, {31'd0, last_taken});
    check("R10", "held target", {8'd0, res_target}, {8'd0, last_target});
    check("R2", "queue drained", 32'(exp_q.size()), 32'd0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule